// File: doc/BRIEF.md
# Upper-Array Write Protection Gate

This block decides whether a pending byte write into a 2048-byte memory, addressed with 11 bits, may go ahead. The host logic presents the write target address every cycle. The single output, `wr_ok`, tells the host whether the array may be changed. When `wr_ok` is low, the host still acknowledges the byte on the bus but leaves the array unchanged.

Only the upper half of the array can be locked. The protected range starts at a 16-byte row inside one of the four upper 256-byte blocks and runs up to the last address. Two pins choose the block. The row number within that block, together with an enable flag, sits in a small protect register. Protection is in force only when the protect pin is high and the stored flag is set. A separate write-control pin blocks every write whatever the other inputs are. The protect register is built from flops and loads from the data bus on an update strobe.

Top module: `wr_guard`

## Requirements
- R1: After reset the protect register reads as zero, its flag is clear, and every address is writable while `wr_ctrl` is low.
- R2: While `wr_ctrl` is high, `wr_ok` is low for every address.
- R3: Addresses 0x000 to 0x3FF are always writable while `wr_ctrl` is low, whatever the protect inputs and register hold.
- R4: An upper-half address is blocked only when `prot_en` is high and the flag (register bit 2) is set. If either is missing, every address is writable while `wr_ctrl` is low.
- R5: When protection is in force, an address is blocked exactly when it is at or above 0x400 + 256*`blk_sel` + 16*row, where row is register bits 7:4. `blk_sel` acts in the same cycle it changes.
- R6: A cycle with `reg_upd` high and `wr_ctrl` low loads `wr_data` into the protect register, and the new value takes effect from the next cycle. A cycle with `reg_upd` high and `wr_ctrl` high leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that clears the protect register |
| prot_en | input | 1 | Protect-enable pin |
| blk_sel | input | 2 | Selects which upper block holds the first protected row |
| wr_ctrl | input | 1 | Write-control pin; high blocks all writes |
| wr_addr | input | 11 | Target address of the pending write |
| reg_upd | input | 1 | Strobe that loads the protect register |
| wr_data | input | 8 | Value loaded into the protect register |
| wr_ok | output | 1 | High when the pending write may change the array |

## Verification
The bench sweeps every address against every combination of block, row, pin and flag state. This catches an off-by-one at the start of the range, which would either lock the row just below the boundary or leave the first protected byte writable. It also catches a swapped row nibble and a block-select weighting error, either of which would move the boundary by whole rows or whole blocks. The bench separately checks that the lower half stays writable and that `wr_ctrl` overrides everything. It also tries a register update while `wr_ctrl` is high: a design that honoured that update would wrongly lock address 0x7FF afterwards.

// File: rtl/wr_guard.sv
module wr_guard #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_en,
  input  logic [1:0]    blk_sel,
  input  logic          wr_ctrl,
  input  logic [AW-1:0] wr_addr,
  input  logic          reg_upd,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ok
);
  localparam int ROW_W = 4;
  localparam int FLAG_BIT = 2;

  logic [DW-1:0] prot_q;
  logic [AW-1:0] bound;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prot_q <= '0;
    else if (reg_upd && !wr_ctrl) prot_q <= wr_data;

  assign bound = {1'b1, blk_sel, prot_q[DW-1 -: ROW_W], {(AW-3-ROW_W){1'b0}}};
  assign armed = prot_en && prot_q[FLAG_BIT];
  assign wr_ok = !wr_ctrl && !(armed && (wr_addr >= bound));
endmodule

// File: rtl/wr_guard_chk.sv
module wr_guard_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prot_en,
  input logic          wr_ctrl,
  input logic [AW-1:0] wr_addr,
  input logic          reg_upd,
  input logic [DW-1:0] prot_q,
  input logic          wr_ok
);
  a_r2_wc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |-> !wr_ok);
  a_r3_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !wr_addr[AW-1]) |-> wr_ok);
  a_r4_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !prot_en) |-> wr_ok);
  a_r5_top_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && prot_en && prot_q[2] && (&wr_addr)) |-> !wr_ok);
  a_r6_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_upd || wr_ctrl) |=> $stable(prot_q));
endmodule

bind wr_guard wr_guard_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .wr_ctrl(wr_ctrl),
  .wr_addr(wr_addr), .reg_upd(reg_upd), .prot_q(prot_q), .wr_ok(wr_ok)
);

// File: tb/sim_wr_guard.sv
`timescale 1ns/1ps
module sim_wr_guard;
  logic clk = 0, rst_n = 0, prot_en = 0, wr_ctrl = 0, reg_upd = 0;
  logic [1:0] blk_sel = 0;
  logic [10:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic wr_ok;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  wr_guard u0 (.clk(clk), .rst_n(rst_n), .prot_en(prot_en), .blk_sel(blk_sel),
    .wr_ctrl(wr_ctrl), .wr_addr(wr_addr), .reg_upd(reg_upd), .wr_data(wr_data),
    .wr_ok(wr_ok));

  task automatic chk(input string req, input logic exp);
    #1;
    checks++;
    if (wr_ok !== exp) begin
      errs++;
      $display("FAIL %s addr=%h pe=%b bs=%0d wc=%b: got %b expected %b",
               req, wr_addr, prot_en, blk_sel, wr_ctrl, wr_ok, exp);
    end
  endtask

  task automatic load(input logic [7:0] v, input logic wc);
    @(negedge clk);
    wr_data = v; reg_upd = 1; wr_ctrl = wc;
    @(negedge clk);
    reg_upd = 0; wr_ctrl = 0;
  endtask

  function automatic logic model(input int a, input logic pe, input logic fl,
                                 input int bs, input int row, input logic wc);
    return !wc && !(pe && fl && a >= 1024 + 256*bs + 16*row);
  endfunction

  task automatic done();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000*8);
    errs++; checks++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: reset leaves all writable even with pin high
    prot_en = 1;
    for (int a = 0; a < 2048; a += 97) begin wr_addr = 11'(a); chk("R1", 1'b1); end
    wr_addr = 11'h7FF; chk("R1", 1'b1);
    // R6: update ignored while wr_ctrl high
    load(8'h04, 1'b1);
    wr_addr = 11'h7FF; chk("R6", 1'b1);
    for (int fl = 0; fl < 2; fl++)
      for (int row = 0; row < 16; row++) begin
        load(8'((row << 4) | (fl << 2)), 1'b0);
        // R6: new value active next cycle
        prot_en = 1; blk_sel = 3; wr_ctrl = 0; wr_addr = 11'h7FF;
        chk("R6", model(2047, 1, fl[0], 3, row, 0));
        for (int pe = 0; pe < 2; pe++)
          for (int bs = 0; bs < 4; bs++)
            for (int wc = 0; wc < 2; wc++)
              for (int a = 0; a < 2048; a += (pe == 1 && fl == 1 && wc == 0) ? 1 : 5) begin
                prot_en = pe[0]; blk_sel = 2'(bs); wr_ctrl = wc[0]; wr_addr = 11'(a);
                if (wc == 1) chk("R2", 1'b0);
                else if (a < 1024) chk("R3", 1'b1);
                else if (!(pe == 1 && fl == 1)) chk("R4", 1'b1);
                else chk("R5", model(a, 1, 1, bs, row, 0));
              end
        wr_ctrl = 0;
      end
    done();
  end
endmodule